// File: doc/BRIEF.md
# One-Wire RGB Pixel Serializer

This block turns a stream of 24-bit colour words into the single-line pulse-width waveform that chained addressable RGB LEDs expect. Every bit is sent as a high phase and then a low phase. The lengths of those phases decide whether the receiving LED reads the bit as a one or a zero. All four phase lengths are programmed in clock cycles, so the block can match a range of LED families and module clock rates.

A transfer starts with a one-cycle start pulse while the enable is high. The block then fetches pixel words through a valid/ready handshake. It reorders each word's three colour bytes according to a 3-bit order code and shifts the bits onto the line. After the programmed number of pixels, it holds the line low for a programmed latch gap and then pulses done for one cycle.

An internal one-word slot fetches the next pixel while the current one is on the wire, so back-to-back pixels carry no extra idle time. If no word is available when one is needed, the line stays low until a word arrives.

Top module: `rgbser_top`

## Requirements
- R1: During and right after reset, `line_o`, `done_o` and `px_ready_o` are all low.
- R2: A one bit is high for `one_hi_i` cycles and then low for `one_lo_i` cycles. A zero bit is high for `zero_hi_i` cycles and then low for `zero_lo_i` cycles. A programmed value of 0 behaves as 1 cycle.
- R3: A pixel word holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Bytes go out in the order that `order_i` names, first letter first: 0=RGB, 1=RBG, 2=GRB, 3=GBR, 4=BRG, 5=BGR, and 6 or 7 behave as GRB. Within a byte the most significant bit goes first. The order code is applied to each word at the moment it is accepted.
- R4: A transfer sends exactly `pix_count_i` pixels, sampled at start. After the low phase of the final bit, the line stays low for `latch_gap_i` cycles (0 behaves as 1). Then `done_o` is high for exactly one cycle.
- R5: `px_ready_o` is high only while a transfer runs, the slot is empty and words are still owed. Exactly `pix_count_i` words are accepted per transfer, however many are offered.
- R6: When the next pixel is not yet available at a pixel boundary, the line stays low until a word arrives. Every bit of that pixel and the next still keeps its programmed widths.
- R7: While `en_i` is low the line is low, no transfer runs and start pulses are ignored. Dropping `en_i` mid-transfer aborts it on the next cycle without a done pulse.
- R8: A transfer started with `pix_count_i` = 0 sends no bits, holds the line low for the latch gap and then pulses done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock; all timing counts are in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low aborts and idles the line |
| start_i | input | 1 | One-cycle pulse that begins a transfer |
| pix_count_i | input | 13 | Pixels in the transfer |
| order_i | input | 3 | Colour byte order code |
| one_hi_i | input | 6 | High cycles of a one bit |
| one_lo_i | input | 5 | Low cycles of a one bit |
| zero_hi_i | input | 5 | High cycles of a zero bit |
| zero_lo_i | input | 6 | Low cycles of a zero bit |
| latch_gap_i | input | 13 | Low cycles held after the last pixel |
| px_valid_i | input | 1 | Pixel word offered |
| px_data_i | input | 24 | Pixel word, red/green/blue from the top byte down |
| px_ready_o | output | 1 | Pixel word taken when valid and ready are both high |
| line_o | output | 1 | Serial output line |
| done_o | output | 1 | One-cycle pulse at transfer end |

## Verification
A corrupted shift register or bit index shows up as wrong decoded bit values, or as a bit total other than 24 per pixel. Both are visible at the line within one pixel time. A phase counter loaded with the wrong value shows up as a high or low width that differs from the programmed count on the very next bit. A pixel or fetch counter that slips shows up as the wrong number of bits before the gap, as a done pulse that never comes, or as an accepted-word total different from the requested count. These are all visible by the end of the transfer. A slot that fails to empty or fill shows up either as a stall with the line low that never ends, or as a pixel sent twice.

// File: rtl/rgbser_pkg.sv
package rgbser_pkg;

    localparam int PIX_W = 24;
    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_HIGH = 3'd2,
        ST_LOW  = 3'd3,
        ST_GAP  = 3'd4
    } ser_state_e;

    localparam logic [2:0] ORD_RGB = 3'd0;
    localparam logic [2:0] ORD_RBG = 3'd1;
    localparam logic [2:0] ORD_GRB = 3'd2;
    localparam logic [2:0] ORD_GBR = 3'd3;
    localparam logic [2:0] ORD_BRG = 3'd4;
    localparam logic [2:0] ORD_BGR = 3'd5;

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rgbser_reorder.sv
module rgbser_reorder
    import rgbser_pkg::*;
(
    input  logic [2:0]       order_i,
    input  logic [PIX_W-1:0] word_i,
    output logic [PIX_W-1:0] word_o
);

    logic [BYTE_W-1:0] red, grn, blu;

    assign red = word_i[23:16];
    assign grn = word_i[15:8];
    assign blu = word_i[7:0];

    always_comb begin
        unique case (order_i)
            ORD_RGB: word_o = {red, grn, blu};
            ORD_RBG: word_o = {red, blu, grn};
            ORD_GRB: word_o = {grn, red, blu};
            ORD_GBR: word_o = {grn, blu, red};
            ORD_BRG: word_o = {blu, red, grn};
            ORD_BGR: word_o = {blu, grn, red};
            default: word_o = {grn, red, blu};
        endcase
    end

endmodule

// File: rtl/rgbser_slot.sv
module rgbser_slot
    import rgbser_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             load_i,
    input  logic             take_i,
    input  logic [PIX_W-1:0] word_i,
    output logic             full_o,
    output logic [PIX_W-1:0] word_o
);

    typedef struct packed {
        logic             full;
        logic [PIX_W-1:0] word;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take_i) begin
            slot_d.full = 1'b0;
        end
        if (load_i) begin
            slot_d.full = 1'b1;
            slot_d.word = word_i;
        end
        if (flush_i) begin
            slot_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign full_o = slot_q.full;
    assign word_o = slot_q.word;

endmodule

// File: rtl/rgbser_ctrl.sv
module rgbser_ctrl
    import rgbser_pkg::*;
#(
    parameter int ONE_HI_W  = 6,
    parameter int ONE_LO_W  = 5,
    parameter int ZERO_HI_W = 5,
    parameter int ZERO_LO_W = 6,
    parameter int GAP_W     = 13,
    parameter int LEN_W     = 13
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 start_i,
    input  logic [LEN_W-1:0]     pix_count_i,
    input  logic [ONE_HI_W-1:0]  one_hi_i,
    input  logic [ONE_LO_W-1:0]  one_lo_i,
    input  logic [ZERO_HI_W-1:0] zero_hi_i,
    input  logic [ZERO_LO_W-1:0] zero_lo_i,
    input  logic [GAP_W-1:0]     latch_gap_i,
    input  logic                 slot_full_i,
    input  logic [PIX_W-1:0]     slot_word_i,
    input  logic                 accept_i,
    output logic                 take_o,
    output logic                 want_o,
    output logic                 busy_o,
    output logic                 wait_o,
    output logic                 line_o,
    output logic                 done_o
);

    localparam int PHASE_W = maxi(maxi(ONE_HI_W, ONE_LO_W), maxi(ZERO_HI_W, ZERO_LO_W));
    localparam int CW      = maxi(PHASE_W, GAP_W);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(PIX_W - 1);

    typedef struct packed {
        ser_state_e           st;
        logic [PIX_W-1:0]     sh;
        logic [BIT_IDX_W-1:0] bitn;
        logic [CW-1:0]        cnt;
        logic [LEN_W-1:0]     send_left;
        logic [LEN_W-1:0]     fetch_left;
        logic                 line;
        logic                 done;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  take;

    // Cycles minus one; a zero setting still lasts one cycle.
    function automatic logic [CW-1:0] load_of(input logic [CW-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    function automatic logic [CW-1:0] high_for(input logic b);
        return b ? CW'(one_hi_i) : CW'(zero_hi_i);
    endfunction

    function automatic logic [CW-1:0] low_for(input logic b);
        return b ? CW'(one_lo_i) : CW'(zero_lo_i);
    endfunction

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        take     = 1'b0;

        if (accept_i && (c_q.fetch_left != '0)) begin
            c_d.fetch_left = c_q.fetch_left - 1'b1;
        end

        unique case (c_q.st)
            ST_IDLE: begin
                if (en_i && start_i) begin
                    c_d.send_left  = pix_count_i;
                    c_d.fetch_left = pix_count_i;
                    c_d.bitn       = '0;
                    if (pix_count_i == '0) begin
                        c_d.st  = ST_GAP;
                        c_d.cnt = load_of(CW'(latch_gap_i));
                    end else begin
                        c_d.st = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (slot_full_i) begin
                    take     = 1'b1;
                    c_d.sh   = slot_word_i;
                    c_d.bitn = LAST_BIT;
                    c_d.st   = ST_HIGH;
                    c_d.cnt  = load_of(high_for(slot_word_i[PIX_W-1]));
                end
            end
            ST_HIGH: begin
                if (c_q.cnt == '0) begin
                    c_d.st  = ST_LOW;
                    c_d.cnt = load_of(low_for(c_q.sh[PIX_W-1]));
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_LOW: begin
                if (c_q.cnt != '0) begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end else if (c_q.bitn != '0) begin
                    c_d.sh   = {c_q.sh[PIX_W-2:0], 1'b0};
                    c_d.bitn = c_q.bitn - 1'b1;
                    c_d.st   = ST_HIGH;
                    c_d.cnt  = load_of(high_for(c_q.sh[PIX_W-2]));
                end else begin
                    c_d.send_left = c_q.send_left - 1'b1;
                    if (c_q.send_left == LEN_W'(1)) begin
                        c_d.st  = ST_GAP;
                        c_d.cnt = load_of(CW'(latch_gap_i));
                    end else if (slot_full_i) begin
                        take     = 1'b1;
                        c_d.sh   = slot_word_i;
                        c_d.bitn = LAST_BIT;
                        c_d.st   = ST_HIGH;
                        c_d.cnt  = load_of(high_for(slot_word_i[PIX_W-1]));
                    end else begin
                        c_d.st = ST_WAIT;
                    end
                end
            end
            ST_GAP: begin
                if (c_q.cnt == '0) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase

        if (!en_i) begin
            c_d.st   = ST_IDLE;
            c_d.done = 1'b0;
            take     = 1'b0;
        end

        c_d.line = (c_d.st == ST_HIGH);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign take_o = take;
    assign busy_o = (c_q.st != ST_IDLE);
    assign want_o = busy_o && (c_q.fetch_left != '0);
    assign wait_o = (c_q.st == ST_WAIT);
    assign line_o = c_q.line;
    assign done_o = c_q.done;

endmodule

// File: rtl/rgbser_top.sv
module rgbser_top
    import rgbser_pkg::*;
#(
    parameter int ONE_HI_W  = 6,
    parameter int ONE_LO_W  = 5,
    parameter int ZERO_HI_W = 5,
    parameter int ZERO_LO_W = 6,
    parameter int GAP_W     = 13,
    parameter int LEN_W     = 13
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 start_i,
    input  logic [LEN_W-1:0]     pix_count_i,
    input  logic [2:0]           order_i,
    input  logic [ONE_HI_W-1:0]  one_hi_i,
    input  logic [ONE_LO_W-1:0]  one_lo_i,
    input  logic [ZERO_HI_W-1:0] zero_hi_i,
    input  logic [ZERO_LO_W-1:0] zero_lo_i,
    input  logic [GAP_W-1:0]     latch_gap_i,
    input  logic                 px_valid_i,
    input  logic [PIX_W-1:0]     px_data_i,
    output logic                 px_ready_o,
    output logic                 line_o,
    output logic                 done_o
);

    logic             ctrl_busy, ctrl_want, ctrl_wait, ctrl_take;
    logic             slot_full, accept;
    logic [PIX_W-1:0] ordered_word, slot_word;

    assign px_ready_o = ctrl_want && !slot_full;
    assign accept     = px_valid_i && px_ready_o;

    rgbser_reorder u_reorder (
        .order_i (order_i),
        .word_i  (px_data_i),
        .word_o  (ordered_word)
    );

    rgbser_slot u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .flush_i (!ctrl_busy),
        .load_i  (accept),
        .take_i  (ctrl_take),
        .word_i  (ordered_word),
        .full_o  (slot_full),
        .word_o  (slot_word)
    );

    rgbser_ctrl #(
        .ONE_HI_W  (ONE_HI_W),
        .ONE_LO_W  (ONE_LO_W),
        .ZERO_HI_W (ZERO_HI_W),
        .ZERO_LO_W (ZERO_LO_W),
        .GAP_W     (GAP_W),
        .LEN_W     (LEN_W)
    ) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (en_i),
        .start_i     (start_i),
        .pix_count_i (pix_count_i),
        .one_hi_i    (one_hi_i),
        .one_lo_i    (one_lo_i),
        .zero_hi_i   (zero_hi_i),
        .zero_lo_i   (zero_lo_i),
        .latch_gap_i (latch_gap_i),
        .slot_full_i (slot_full),
        .slot_word_i (slot_word),
        .accept_i    (accept),
        .take_o      (ctrl_take),
        .want_o      (ctrl_want),
        .busy_o      (ctrl_busy),
        .wait_o      (ctrl_wait),
        .line_o      (line_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/rgbser_checks.sv
module rgbser_checks #(
    parameter int HI_LIMIT = 64
) (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic line_o,
    input logic done_o,
    input logic px_ready_o,
    input logic busy_i,
    input logic wait_i,
    input logic slot_full_i
);

    logic [7:0] hi_run;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_run <= '0;
        end else if (!line_o) begin
            hi_run <= '0;
        end else if (hi_run != 8'hFF) begin
            hi_run <= hi_run + 1'b1;
        end
    end

    AST_LINE_LOW_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !line_o); // R7
    AST_NO_DONE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !done_o); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R4
    AST_DONE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !line_o); // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(busy_i)); // R4
    AST_READY_NEEDS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        px_ready_o |-> (busy_i && !slot_full_i)); // R5
    AST_UNDERRUN_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wait_i |-> !line_o); // R6
    AST_HIGH_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_o |-> (hi_run < 8'(HI_LIMIT))); // R2

endmodule

bind rgbser_top rgbser_checks u_checks (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .line_o      (line_o),
    .done_o      (done_o),
    .px_ready_o  (px_ready_o),
    .busy_i      (ctrl_busy),
    .wait_i      (ctrl_wait),
    .slot_full_i (slot_full)
);

// File: tb/rgbser_top_bench.sv
module rgbser_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        start = 1'b0;
    logic [12:0] pix_count = '0;
    logic [2:0]  order = '0;
    logic [5:0]  one_hi = '0;
    logic [4:0]  one_lo = '0;
    logic [4:0]  zero_hi = '0;
    logic [5:0]  zero_lo = '0;
    logic [12:0] latch_gap = '0;
    logic        px_valid = 1'b0;
    logic [23:0] px_data = '0;
    logic        px_ready, line, done;

    int checks = 0;
    int fails = 0;
    logic [23:0] pix [0:15];

    always #2 clk = ~clk;

    rgbser_top u_rgbser_top (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .en_i        (en),
        .start_i     (start),
        .pix_count_i (pix_count),
        .order_i     (order),
        .one_hi_i    (one_hi),
        .one_lo_i    (one_lo),
        .zero_hi_i   (zero_hi),
        .zero_lo_i   (zero_lo),
        .latch_gap_i (latch_gap),
        .px_valid_i  (px_valid),
        .px_data_i   (px_data),
        .px_ready_o  (px_ready),
        .line_o      (line),
        .done_o      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Wire byte order, from the order code table in the requirements.
    function automatic logic [23:0] exp_word(input int code, input logic [23:0] w);
        logic [7:0] col [0:2];
        int s0, s1, s2;
        col[0] = w[23:16];
        col[1] = w[15:8];
        col[2] = w[7:0];
        case (code)
            0: begin s0 = 0; s1 = 1; s2 = 2; end
            1: begin s0 = 0; s1 = 2; s2 = 1; end
            3: begin s0 = 1; s1 = 2; s2 = 0; end
            4: begin s0 = 2; s1 = 0; s2 = 1; end
            5: begin s0 = 2; s1 = 1; s2 = 0; end
            default: begin s0 = 1; s1 = 0; s2 = 2; end
        endcase
        return {col[s0], col[s1], col[s2]};
    endfunction

    task automatic run_xfer(input int code, input int n, input int oh, input int ol,
                            input int zh, input int zl, input int g, input bit stall);
        int hl [0:255];
        int ll [0:255];
        int acc, nb, hi_len, lo_len, done_cnt, tail, after;
        int bad_b, bad_h, bad_l, exp_tail;
        logic prev;
        bit stall_now;
        for (int i = 0; i < 16; i++) pix[i] = 24'($urandom);
        @(negedge clk);
        en = 1'b1; order = 3'(code); pix_count = 13'(n);
        one_hi = 6'(oh); one_lo = 5'(ol); zero_hi = 5'(zh); zero_lo = 6'(zl);
        latch_gap = 13'(g); start = 1'b1; px_valid = 1'b0;
        acc = 0; nb = 0; hi_len = 0; lo_len = 0; done_cnt = 0; tail = -1; after = 0;
        prev = 1'b0;
        for (int cyc = 0; cyc < 30000 && after < 6; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (line) begin
                if (!prev) begin
                    if (nb > 0 && nb <= 256) ll[nb-1] = lo_len;
                    hi_len = 0;
                end
                hi_len++;
            end else begin
                if (prev) begin
                    if (nb < 256) hl[nb] = hi_len;
                    nb++;
                    lo_len = 0;
                end
                lo_len++;
            end
            prev = line;
            if (done) begin
                done_cnt++;
                if (tail < 0) tail = lo_len - 1;
            end
            if (done_cnt > 0) after++;
            stall_now = stall && (($urandom % 48) != 0);
            px_valid = (acc < n + 2) && !stall_now;
            px_data  = pix[acc % 16];
            if (px_valid && px_ready) acc++;
        end
        px_valid = 1'b0;

        chk(nb == n * 24, "R4", "bits sent", nb, n * 24);
        bad_b = 0; bad_h = 0; bad_l = 0;
        for (int k = 0; k < nb && k < 256; k++) begin
            logic [23:0] w;
            logic b;
            int exph, expl;
            w = exp_word(code, pix[k / 24]);
            b = w[23 - (k % 24)];
            exph = b ? eff(oh) : eff(zh);
            if (hl[k] != exph) bad_h++;
            if ((hl[k] == eff(oh)) != b) bad_b++;
            if (k < nb - 1) begin
                expl = b ? eff(ol) : eff(zl);
                if (stall && (k % 24 == 23)) begin
                    if (ll[k] < expl) bad_l++;
                end else if (ll[k] != expl) begin
                    bad_l++;
                end
            end
        end
        chk(bad_b == 0, "R3", "bit values in wrong order", bad_b, 0);
        chk(bad_h == 0, "R2", "high phase widths wrong", bad_h, 0);
        if (stall) chk(bad_l == 0, "R6", "low widths around underrun", bad_l, 0);
        else       chk(bad_l == 0, "R2", "low phase widths wrong", bad_l, 0);
        if (n == 0) begin
            exp_tail = eff(g);
        end else begin
            logic [23:0] lw;
            lw = exp_word(code, pix[(n - 1) % 16]);
            exp_tail = (lw[0] ? eff(ol) : eff(zl)) + eff(g);
        end
        if (n == 0) chk(tail == exp_tail, "R8", "gap before done", tail, exp_tail);
        else        chk(tail == exp_tail, "R4", "low cycles before done", tail, exp_tail);
        chk(done_cnt == 1, "R4", "done pulses", done_cnt, 1);
        chk(acc == n, "R5", "words accepted", acc, n);
    endtask

    task automatic abort_case();
        int bad;
        for (int i = 0; i < 16; i++) pix[i] = 24'($urandom);
        @(negedge clk);
        en = 1'b1; pix_count = 13'd4; order = 3'd2;
        one_hi = 6'd5; one_lo = 5'd2; zero_hi = 5'd2; zero_lo = 6'd5;
        latch_gap = 13'd10; start = 1'b1;
        @(negedge clk);
        start = 1'b0; px_valid = 1'b1; px_data = pix[0];
        repeat (60) @(negedge clk);
        en = 1'b0; px_valid = 1'b0;
        @(negedge clk);
        chk(!line && !px_ready, "R7", "line/ready one cycle after enable drop",
            int'(line) + 2 * int'(px_ready), 0);
        bad = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (line || done || px_ready) bad++;
        end
        chk(bad == 0, "R7", "activity after abort", bad, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (line || done || px_ready) bad++;
        end
        chk(bad == 0, "R7", "start ignored while disabled", bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int oh, zh;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!line && !done && !px_ready, "R1", "outputs in reset",
            int'(line) + int'(done) + int'(px_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!line && !done && !px_ready, "R1", "outputs after reset",
            int'(line) + int'(done) + int'(px_ready), 0);

        run_xfer(2, 2, 6, 2, 2, 6, 8, 1'b0);
        run_xfer(6, 1, 4, 1, 2, 3, 3, 1'b0);
        run_xfer(7, 1, 3, 2, 1, 1, 2, 1'b0);
        run_xfer(0, 3, 0, 0, 2, 0, 0, 1'b0);
        run_xfer(5, 0, 3, 1, 1, 3, 25, 1'b0);
        run_xfer(4, 3, 3, 1, 1, 2, 300, 1'b1);
        abort_case();
        run_xfer(1, 2, 4, 2, 2, 4, 5, 1'b0);
        for (int t = 0; t < 8; t++) begin
            oh = 1 + int'($urandom % 6);
            zh = oh + 1 + int'($urandom % 3);
            run_xfer(int'($urandom % 8), 1 + int'($urandom % 6), oh,
                     int'($urandom % 5), zh, int'($urandom % 6),
                     int'($urandom % 40), bit'(t % 2));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule